// File: doc/BRIEF.md
# RTC Millisecond Countdown Wake Alarm

An always-on time counter that runs from a 32.768 kHz reference. Each reference period arrives as a one-cycle strobe on `ref_tick_i`, synchronous to the block clock. A fractional accumulator turns these strobes into millisecond ticks. The ticks drive a millisecond counter, which carries into a seconds counter. Once every eight reference periods the block spends one period copying the live seconds value into a shadow that software reads. That period is flagged as busy.

The block also holds a one-shot countdown alarm measured in milliseconds. Software arms it by writing a count with the top bit set. When it expires, it sets a pending bit in a write-one-to-clear status register. If the matching mask bit is set, the pending bit raises an active-high level interrupt that can wake the system.

Reads are allowed at any time. A write that lands inside the busy period is discarded and recorded in a sticky error flag. Software therefore waits for busy to fall before it writes.

Top module: `rtc_wake_alarm`

## Requirements
- R1: Bit 0 of offset 0x004 reads 1 during exactly one of every eight reference periods. The seconds value at offset 0x008 is refreshed from the live count only when that busy period ends.
- R2: Reads are allowed at any time. A write made while busy is 1 changes no register and sets bit 1 of offset 0x004. A write of 1 to that bit while not busy clears it.
- R3: Offset 0x024 holds the alarm: bit 31 is the enable and bits 27:0 are the count. Bits 30:28 read 0. Writing zero disarms the alarm.
- R4: While the alarm is enabled, each millisecond tick decrements the count. A tick that arrives with the count at 1 or 0 leaves the count at 0, clears the enable and sets bit 4 of offset 0x02C. A write to 0x024 in the same cycle takes precedence over the tick.
- R5: Offset 0x02C is write-one-to-clear. A new expiry in the same cycle as a clear leaves the bit set.
- R6: `irq_o` is high exactly while status bit 4 and mask bit 4 (offset 0x028) are both 1. The other mask bits read 0.
- R7: Each reference strobe adds TICK_HZ to an accumulator. A millisecond tick occurs on a strobe whose sum reaches REF_HZ, and REF_HZ is then subtracted.
- R8: The millisecond count wraps at MS_PER_SEC and increments the seconds count when it wraps.
- R9: After reset, every register reads zero and `irq_o` is low.
- R10: Offsets outside the five defined ones read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | One-cycle strobe per 32.768 kHz reference period |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the request |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Level alarm interrupt, active high |

## Verification
A drift in the millisecond accumulator or counter appears first as an alarm that expires one tick early or late. That shows on `irq_o` within a few reference periods of arming. It appears in the seconds readout only at the next busy period, at most eight periods later. A write gate that is wrong shows on the very next read: the target register changes when it should not, or the error flag does not change. The bench tracks every register cycle by cycle from the requirements. It compares every read and the interrupt on every cycle, so any divergence is reported on the cycle it first becomes visible.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] OFF_BUSY  = 8'h04;
  localparam logic [AW-1:0] OFF_SEC   = 8'h08;
  localparam logic [AW-1:0] OFF_ALARM = 8'h24;
  localparam logic [AW-1:0] OFF_MASK  = 8'h28;
  localparam logic [AW-1:0] OFF_STAT  = 8'h2C;
  localparam int ALARM_EN_BIT  = 31;
  localparam int ALARM_CNT_W   = 28;
  localparam int ALARM_IRQ_BIT = 4;
  localparam int BUSY_BIT      = 0;
  localparam int DROP_BIT      = 1;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int REF_HZ  = 32768,
  parameter int TICK_HZ = 1000,
  parameter int PHASES  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  output logic busy_o,
  output logic copy_o,
  output logic ms_tick_o
);
  localparam int PH_W  = $clog2(PHASES);
  localparam int ACC_W = $clog2(REF_HZ + TICK_HZ + 1);

  logic [PH_W-1:0]  phase_q;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic             carry;

  assign acc_sum   = acc_q + ACC_W'(TICK_HZ);
  assign carry     = acc_sum >= ACC_W'(REF_HZ);
  assign busy_o    = phase_q == PH_W'(PHASES - 1);
  assign copy_o    = ref_tick_i & busy_o;
  assign ms_tick_o = ref_tick_i & carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else if (ref_tick_i) begin
      phase_q <= busy_o ? '0 : phase_q + 1'b1;
      acc_q   <= carry ? acc_sum - ACC_W'(REF_HZ) : acc_sum;
    end
  end
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ms_tick_i,
  input  logic             copy_i,
  output logic [MS_W-1:0]  ms_o,
  output logic [SEC_W-1:0] sec_shadow_o
);
  logic [MS_W-1:0]  ms_q;
  logic [SEC_W-1:0] sec_q, shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_q     <= '0;
      sec_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (copy_i) shadow_q <= sec_q;
      if (ms_tick_i) begin
        if (ms_q == MS_W'(MS_PER_SEC - 1)) begin
          ms_q  <= '0;
          sec_q <= sec_q + 1'b1;
        end else begin
          ms_q <= ms_q + 1'b1;
        end
      end
    end
  end

  assign ms_o         = ms_q;
  assign sec_shadow_o = shadow_q;
endmodule

// File: rtl/rtc_countdown.sv
module rtc_countdown #(
  parameter int CNT_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             ms_tick_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = cnt_q <= CNT_W'(1);
  assign expire_o = !wr_i && ms_tick_i && en_q && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (wr_i) begin
      en_q  <= wr_en_i;
      cnt_q <= wr_cnt_i;
    end else if (ms_tick_i && en_q) begin
      if (last) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign en_o  = en_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_wake_alarm.sv
module rtc_wake_alarm
  import rtc_wake_pkg::*;
#(
  parameter int REF_HZ     = 32768,
  parameter int TICK_HZ    = 1000,
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int MS_W = $clog2(MS_PER_SEC);

  logic                   busy, copy, ms_tick;
  logic [MS_W-1:0]        ms_cnt;
  logic [SEC_W-1:0]       sec_shadow;
  logic                   alarm_en, alarm_expire;
  logic [ALARM_CNT_W-1:0] alarm_cnt;
  logic                   err_q, mask_q, status_q;
  logic                   wr_ok, wr_drop;

  assign wr_ok   = req_i & we_i & ~busy;
  assign wr_drop = req_i & we_i & busy;

  rtc_timebase #(.REF_HZ(REF_HZ), .TICK_HZ(TICK_HZ), .PHASES(8)) u_tb (
    .clk_i, .rst_ni, .ref_tick_i,
    .busy_o(busy), .copy_o(copy), .ms_tick_o(ms_tick)
  );

  rtc_time_count #(.MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W)) u_cnt (
    .clk_i, .rst_ni, .ms_tick_i(ms_tick), .copy_i(copy),
    .ms_o(ms_cnt), .sec_shadow_o(sec_shadow)
  );

  rtc_countdown #(.CNT_W(ALARM_CNT_W)) u_cd (
    .clk_i, .rst_ni,
    .wr_i(wr_ok && addr_i == OFF_ALARM),
    .wr_en_i(wdata_i[ALARM_EN_BIT]),
    .wr_cnt_i(wdata_i[ALARM_CNT_W-1:0]),
    .ms_tick_i(ms_tick),
    .en_o(alarm_en), .cnt_o(alarm_cnt), .expire_o(alarm_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      mask_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (wr_drop) err_q <= 1'b1;
      else if (wr_ok && addr_i == OFF_BUSY && wdata_i[DROP_BIT]) err_q <= 1'b0;
      if (wr_ok && addr_i == OFF_MASK) mask_q <= wdata_i[ALARM_IRQ_BIT];
      // expiry wins over a same-cycle clear
      if (alarm_expire) status_q <= 1'b1;
      else if (wr_ok && addr_i == OFF_STAT && wdata_i[ALARM_IRQ_BIT]) status_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_BUSY: begin
        rdata_o[BUSY_BIT] = busy;
        rdata_o[DROP_BIT] = err_q;
      end
      OFF_SEC:   rdata_o = DW'(sec_shadow);
      OFF_ALARM: begin
        rdata_o[ALARM_EN_BIT]      = alarm_en;
        rdata_o[ALARM_CNT_W-1:0]   = alarm_cnt;
      end
      OFF_MASK:  rdata_o[ALARM_IRQ_BIT] = mask_q;
      OFF_STAT:  rdata_o[ALARM_IRQ_BIT] = status_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = status_q & mask_q;
endmodule

// File: rtl/rtc_wake_alarm_chk.sv
module rtc_wake_alarm_chk
  import rtc_wake_pkg::*;
#(
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ref_tick_i,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic            busy,
  input logic            err,
  input logic            mask,
  input logic            status,
  input logic            alarm_en,
  input logic [MS_W-1:0] ms,
  input logic            irq_o
);
  p_busy_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_tick_i |=> $stable(busy));

  p_drop_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && busy) |=> err);

  p_drop_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && busy) |=> $stable(mask));

  p_oneshot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(alarm_en) && !$past(req_i && we_i && !busy && addr_i == OFF_ALARM)) |-> status);

  p_irq_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask && status));

  p_ms_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms < MS_W'(MS_PER_SEC));
endmodule

bind rtc_wake_alarm rtc_wake_alarm_chk #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .req_i(req_i),
  .we_i(we_i), .addr_i(addr_i), .busy(busy), .err(err_q), .mask(mask_q),
  .status(status_q), .alarm_en(alarm_en), .ms(ms_cnt), .irq_o(irq_o)
);

// File: tb/tb_rtc_wake_alarm.sv
module tb_rtc_wake_alarm;
  localparam int REF_HZ = 100, TICK_HZ = 30, MS_PER_SEC = 10, TICK_DIV = 3;

  logic clk = 0, rst_n = 0, ref_tick = 0, req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_wake_alarm #(.REF_HZ(REF_HZ), .TICK_HZ(TICK_HZ), .MS_PER_SEC(MS_PER_SEC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // reference strobe generator
  int div_cnt = 0;
  always @(negedge clk) begin
    div_cnt  <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
    ref_tick <= rst_n && (div_cnt == TICK_DIV - 1);
  end

  // requirement model
  int m_phase, m_acc, m_ms;
  logic [31:0] m_sec, m_shadow;
  logic m_en, m_err, m_mask, m_stat;
  logic [27:0] m_cnt;
  function automatic logic m_busy(); return m_phase == 7; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_acc = 0; m_ms = 0; m_sec = 0; m_shadow = 0;
      m_en = 0; m_cnt = 0; m_err = 0; m_mask = 0; m_stat = 0;
    end else begin
      logic ok, tick, wa, expire;
      ok = req && we && !m_busy();
      tick = 0;
      if (req && we && m_busy()) m_err = 1;
      else if (ok && addr == 8'h04 && wdata[1]) m_err = 0;
      if (ref_tick) begin
        if (m_phase == 7) m_shadow = m_sec;
        m_phase = (m_phase + 1) % 8;
        m_acc += TICK_HZ;
        if (m_acc >= REF_HZ) begin m_acc -= REF_HZ; tick = 1; end
      end
      if (tick) begin
        if (m_ms == MS_PER_SEC - 1) begin m_ms = 0; m_sec++; end else m_ms++;
      end
      wa = ok && addr == 8'h24;
      expire = 0;
      if (wa) begin m_en = wdata[31]; m_cnt = wdata[27:0]; end
      else if (tick && m_en) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_en = 0; expire = 1; end else m_cnt--;
      end
      if (ok && addr == 8'h28) m_mask = wdata[4];
      if (expire) m_stat = 1;
      else if (ok && addr == 8'h2C && wdata[4]) m_stat = 0;
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h04: return {30'd0, m_err, m_busy()};
      8'h08: return m_shadow;
      8'h24: return {m_en, 3'd0, m_cnt};
      8'h28: return {27'd0, m_mask, 4'd0};
      8'h2C: return {27'd0, m_stat, 4'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h04: return "R1/R2";
      8'h08: return "R1/R7/R8";
      8'h24: return "R3/R4";
      8'h28: return "R6";
      8'h2C: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // irq compared on every cycle (R6)
  always @(negedge clk) if (rst_n && !done) begin
    #1;
    if (irq !== (m_stat && m_mask)) begin
      n_tests++; n_fail++;
      $display("FAIL R6 irq: actual %b expected %b", irq, m_stat && m_mask);
    end
  end

  task automatic rd(logic [7:0] a, string tag = "");
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 check(tag == "" ? tag_of(a) : tag, rdata, exp_rd(a));
    @(negedge clk); req = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, bit safe = 1);
    @(negedge clk);
    while (safe && m_busy()) @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] addrs [6] = '{8'h04, 8'h08, 8'h24, 8'h28, 8'h2C, 8'h10};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state, all checked against zero explicitly
    foreach (addrs[i]) begin
      @(negedge clk); req = 1; addr = addrs[i];
      #1 check("R9", rdata, 32'd0);
    end
    check("R9 irq", {31'd0, irq}, 32'd0);
    rst_n = 1; req = 0;

    // R10 undefined offset ignores writes
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R10");
    // R6 mask reads only bit 4
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, "R6");
    // R3 reserved bits read 0
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, "R3");
    wr(8'h24, 32'h0); rd(8'h24, "R3 disarm");
    idle(200); rd(8'h2C, "R3 disarm no expiry");

    // R4 short countdown expires and raises irq
    wr(8'h24, 32'h8000_0003);
    idle(60); rd(8'h24, "R4 one-shot"); rd(8'h2C, "R4 status");
    check("R4 irq", {31'd0, irq}, 32'd1);
    // R5 W1C all ones
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, "R5 clear");
    // count of zero with enable expires on next tick
    wr(8'h24, 32'h8000_0000); idle(20); rd(8'h2C, "R4 zero count");
    wr(8'h2C, 32'h10);

    // R2 write during busy is dropped
    @(negedge clk); while (!m_busy()) @(negedge clk);
    wr(8'h28, 32'h0, 0); rd(8'h28, "R2 dropped"); rd(8'h04, "R2 flag");
    wr(8'h04, 32'h2); rd(8'h04, "R2 flag clear");

    // R1 watch busy across several periods
    repeat (30) rd(8'h04, "R1 busy");
    // R8 seconds after rollovers
    idle(400); rd(8'h08, "R8 seconds");

    // constrained random mix
    for (int i = 0; i < 800; i++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] a = addrs[$urandom_range(0, 5)];
      logic [31:0] d = $urandom();
      if (a == 8'h24) d = {d[31], 3'd0, 20'd0, d[7:0] & 8'h1F};
      if (op < 5) rd(a);
      else if (op < 8) wr(a, d, op == 7 ? 0 : 1);
      else idle($urandom_range(1, 12));
    end
    foreach (addrs[i]) rd(addrs[i]);
    finish_run();
  end
endmodule